// File: doc/BRIEF.md
# Stepped LED Brightness Fader

This block sits between the brightness, enable and fade registers of an LED backlight controller and the current-sink setting that is actually applied. Software writes a 5-bit brightness target. With fading off, the applied code follows the target at once. With fading on, the applied code walks one legal setting at a time toward the target. Each step waits a programmable number of millisecond ticks.

The legal codes are 0 (off) and 4 through 31, which gives 29 settings. Codes 1 to 3 are reserved and never appear on the output. A running fade can be redirected to a new target, re-rated, or cancelled. It advances only while at least one channel is enabled, and it pauses, holding its level, while the enable mask is zero.

The control is a three-state machine:

- **FS_STEADY**: the applied code equals the target, or fading is off.
- **FS_FADING**: a fade is stepping.
- **FS_PAUSED**: a fade is pending but every channel is disabled.

The transitions are:

- **start**: STEADY to FADING on a differing target with fading on and the mask non-zero.
- **hold**: STEADY or FADING to PAUSED when the mask becomes zero.
- **resume**: PAUSED to FADING when the mask becomes non-zero.
- **arrive**: FADING or PAUSED to STEADY when the level reaches the target.
- **cancel**: any state to STEADY when fading is cleared.

Top module: `led_fade_ctrl`

## Requirements
- R1: After reset the applied code is 0, all channel outputs are 0 and busy is 0.
- R2: With fading disabled, a write of a legal code sets the applied code to it at the next clock edge, and busy stays 0.
- R3: A brightness write of code 1, 2 or 3 is ignored: neither the target nor the applied code changes, and the applied code is never 1, 2 or 3.
- R4: The fade-rate field sets the ticks per step: 00 gives 32, 01 gives 24, 10 gives 16 and 11 gives 8. A step takes effect at the edge that samples the last tick of the interval.
- R5: With fading enabled, each step moves the applied code by one legal setting toward the target. Busy is 1 while the applied code differs from the target, and it drops when the two are equal.
- R6: A fade-register write during a fade restarts the interval and continues the fade at the new rate from the present level.
- R7: A legal brightness write during a fade redirects it from the present level and restarts the interval.
- R8: Channel output i is 1 exactly when enable bit i is set and the applied code is non-zero.
- R9: A step between code 0 and code 4 is a single step in either direction.
- R10: While the enable mask is zero, a pending fade holds its level and its interval count, with busy still 1. It resumes when a channel is enabled again.
- R11: Clearing the fade enable makes the applied code equal the target at the next edge, and busy goes to 0.
- R12: When a legal brightness write and the tick that completes an interval fall in the same cycle, the write wins: no step is taken and a full new interval starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bri_wr | input | 1 | Brightness register write strobe |
| bri_code | input | CODE_W | Brightness code written |
| ena_wr | input | 1 | Channel enable register write strobe |
| ena_mask | input | CHANNELS | Channel enable bits written |
| fade_wr | input | 1 | Fade register write strobe |
| fade_en | input | 1 | Fade enable written |
| fade_rate | input | RATE_W | Fade rate written |
| ms_tick | input | 1 | One-cycle millisecond tick |
| level_o | output | CODE_W | Applied brightness code |
| chan_on_o | output | CHANNELS | Per-channel drive enable |
| busy_o | output | 1 | Fade in progress |

## Verification
Two functions can fall in the same cycle: a register write, and the tick that finishes a step interval. The bench provokes this on purpose. It holds the tick high for one cycle less than a full interval, then asserts a brightness write in the cycle where the final tick is still high. The result is judged by checking three things: the applied code has not moved after that edge, it is still unchanged one tick short of a further full interval, and it moves on exactly the tick that completes that interval. Pause and cancel are handled the same way: mask writes and fade writes are issued mid-interval, and the bench counts ticks from the write to the step.

// File: rtl/led_fade_pkg.sv
package led_fade_pkg;

    typedef enum logic [1:0] {
        FS_STEADY = 2'd0,
        FS_FADING = 2'd1,
        FS_PAUSED = 2'd2
    } fade_state_t;

endpackage

// File: rtl/fade_step_calc.sv
module fade_step_calc #(
    parameter int CODE_W      = 5,
    parameter int FIRST_LEGAL = 4
) (
    input  logic [CODE_W-1:0] cur_code,
    input  logic [CODE_W-1:0] tgt_code,
    output logic [CODE_W-1:0] nxt_code
);
    localparam logic [CODE_W-1:0] LOW_LEGAL = CODE_W'(FIRST_LEGAL);
    localparam logic [CODE_W-1:0] ONE       = CODE_W'(1);

    // One legal setting toward the target; reserved codes are jumped over
    always_comb begin
        if (cur_code < tgt_code) begin
            nxt_code = (cur_code == '0) ? LOW_LEGAL : cur_code + ONE;
        end else if (cur_code > tgt_code) begin
            nxt_code = (cur_code == LOW_LEGAL) ? '0 : cur_code - ONE;
        end else begin
            nxt_code = cur_code;
        end
    end
endmodule

// File: rtl/fade_interval_timer.sv
module fade_interval_timer #(
    parameter int BASE_TICKS = 8,
    parameter int RATE_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              run,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    output logic              expire
);
    localparam int RATE_LEVELS = 1 << RATE_W;
    localparam int MAX_TICKS   = BASE_TICKS * RATE_LEVELS;
    localparam int CNT_W       = $clog2(MAX_TICKS);
    localparam int PER_W       = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [PER_W-1:0] period_ticks;

    always_comb begin
        period_ticks = PER_W'(BASE_TICKS * (RATE_LEVELS - int'(rate)));
        expire = run && tick && !restart &&
                 ({1'b0, cnt_q} == period_ticks - PER_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/fade_chan_gate.sv
module fade_chan_gate #(
    parameter int CHANNELS = 4
) (
    input  logic [CHANNELS-1:0] mask,
    input  logic                lit,
    output logic [CHANNELS-1:0] chan_on
);
    for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
        assign chan_on[i] = mask[i] & lit;
    end
endmodule

// File: rtl/led_fade_ctrl.sv
module led_fade_ctrl
    import led_fade_pkg::*;
#(
    parameter int CODE_W      = 5,
    parameter int FIRST_LEGAL = 4,
    parameter int CHANNELS    = 4,
    parameter int RATE_W      = 2,
    parameter int BASE_TICKS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bri_wr,
    input  logic [CODE_W-1:0]   bri_code,
    input  logic                ena_wr,
    input  logic [CHANNELS-1:0] ena_mask,
    input  logic                fade_wr,
    input  logic                fade_en,
    input  logic [RATE_W-1:0]   fade_rate,
    input  logic                ms_tick,
    output logic [CODE_W-1:0]   level_o,
    output logic [CHANNELS-1:0] chan_on_o,
    output logic                busy_o
);
    localparam logic [CODE_W-1:0] LOW_LEGAL = CODE_W'(FIRST_LEGAL);

    fade_state_t         state_q, state_n;
    logic [CODE_W-1:0]   level_q, level_n;
    logic [CODE_W-1:0]   tgt_q, tgt_n;
    logic                fen_q, fen_n;
    logic [RATE_W-1:0]   rate_q, rate_n;
    logic [CHANNELS-1:0] mask_q, mask_n;

    logic                bri_legal, take_bri, restart, run, expire;
    logic [CODE_W-1:0]   stepped;

    // Register-write decode
    always_comb begin
        bri_legal = (bri_code == '0) || (bri_code >= LOW_LEGAL);
        take_bri  = bri_wr && bri_legal;
        restart   = take_bri || fade_wr;
        tgt_n     = take_bri ? bri_code : tgt_q;
        fen_n     = fade_wr ? fade_en : fen_q;
        rate_n    = fade_wr ? fade_rate : rate_q;
        mask_n    = ena_wr ? ena_mask : mask_q;
    end

    fade_interval_timer #(
        .BASE_TICKS (BASE_TICKS),
        .RATE_W     (RATE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (run),
        .tick    (ms_tick),
        .rate    (rate_q),
        .expire  (expire)
    );

    fade_step_calc #(
        .CODE_W      (CODE_W),
        .FIRST_LEGAL (FIRST_LEGAL)
    ) u_step (
        .cur_code (level_q),
        .tgt_code (tgt_q),
        .nxt_code (stepped)
    );

    // Next-state and next-level logic
    always_comb begin
        run     = 1'b0;
        level_n = level_q;
        state_n = state_q;
        unique case (state_q)
            FS_STEADY: run = 1'b0;
            FS_FADING: run = 1'b1;
            FS_PAUSED: run = 1'b0;
            default:   run = 1'b0;
        endcase

        if (!fen_n) begin
            level_n = tgt_n;                   // cancel or immediate write
            state_n = FS_STEADY;
        end else begin
            if (expire) begin
                level_n = stepped;
            end
            if (level_n == tgt_n) begin
                state_n = FS_STEADY;           // arrive
            end else if (mask_n != '0) begin
                state_n = FS_FADING;           // start or resume
            end else begin
                state_n = FS_PAUSED;           // hold
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_STEADY;
            level_q <= '0;
            tgt_q   <= '0;
            fen_q   <= 1'b0;
            rate_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_n;
            level_q <= level_n;
            tgt_q   <= tgt_n;
            fen_q   <= fen_n;
            rate_q  <= rate_n;
            mask_q  <= mask_n;
        end
    end

    fade_chan_gate #(
        .CHANNELS (CHANNELS)
    ) u_gate (
        .mask    (mask_q),
        .lit     (level_q != '0),
        .chan_on (chan_on_o)
    );

    // Outputs
    always_comb begin
        level_o = level_q;
        unique case (state_q)
            FS_STEADY: busy_o = 1'b0;
            FS_FADING: busy_o = 1'b1;
            FS_PAUSED: busy_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_fade_ctrl_chk.sv
module led_fade_ctrl_chk #(
    parameter int CODE_W      = 5,
    parameter int FIRST_LEGAL = 4,
    parameter int CHANNELS    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bri_wr,
    input logic [CODE_W-1:0]   bri_code,
    input logic                ena_wr,
    input logic                fade_wr,
    input logic                fade_en,
    input logic [CODE_W-1:0]   level_o,
    input logic [CHANNELS-1:0] chan_on_o,
    input logic                busy_o,
    input logic [CHANNELS-1:0] mask_q,
    input logic                fen_q
);
    localparam logic [CODE_W-1:0] LOW_LEGAL = CODE_W'(FIRST_LEGAL);

    function automatic logic near(input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
        if (a == b) return 1'b1;
        if ((a == '0 && b == LOW_LEGAL) || (a == LOW_LEGAL && b == '0)) return 1'b1;
        if (a >= LOW_LEGAL && b >= LOW_LEGAL &&
            (a - b == CODE_W'(1) || b - a == CODE_W'(1))) return 1'b1;
        return 1'b0;
    endfunction

    logic legal_wr;
    assign legal_wr = bri_wr && (bri_code == '0 || bri_code >= LOW_LEGAL);

    assert_legal_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) || (level_o >= LOW_LEGAL));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bri_wr && !fade_wr) |=> near(level_o, $past(level_o)));

    assert_direct_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fen_q && !fade_wr && legal_wr) |=> (level_o == $past(bri_code)) && !busy_o);

    assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fade_wr && !fade_en) |=> !busy_o);

    assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && mask_q == '0 && !ena_wr && !bri_wr && !fade_wr) |=> $stable(level_o));

    assert_dark_channels_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> (chan_on_o == '0));
endmodule

bind led_fade_ctrl led_fade_ctrl_chk #(
    .CODE_W      (CODE_W),
    .FIRST_LEGAL (FIRST_LEGAL),
    .CHANNELS    (CHANNELS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bri_wr    (bri_wr),
    .bri_code  (bri_code),
    .ena_wr    (ena_wr),
    .fade_wr   (fade_wr),
    .fade_en   (fade_en),
    .level_o   (level_o),
    .chan_on_o (chan_on_o),
    .busy_o    (busy_o),
    .mask_q    (mask_q),
    .fen_q     (fen_q)
);

// File: tb/led_fade_ctrl_tb_top.sv
module led_fade_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bri_wr = 1'b0;
    logic [4:0] bri_code = '0;
    logic       ena_wr = 1'b0;
    logic [3:0] ena_mask = '0;
    logic       fade_wr = 1'b0;
    logic       fade_en = 1'b0;
    logic [1:0] fade_rate = '0;
    logic       ms_tick = 1'b0;
    logic [4:0] level_o;
    logic [3:0] chan_on_o;
    logic       busy_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_fade_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bri_wr(bri_wr), .bri_code(bri_code),
        .ena_wr(ena_wr), .ena_mask(ena_mask), .fade_wr(fade_wr),
        .fade_en(fade_en), .fade_rate(fade_rate), .ms_tick(ms_tick),
        .level_o(level_o), .chan_on_o(chan_on_o), .busy_o(busy_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_bri(input int code);
        bri_code = 5'(code); bri_wr = 1'b1;
        @(negedge clk); bri_wr = 1'b0;
    endtask

    task automatic wr_ena(input int m);
        ena_mask = 4'(m); ena_wr = 1'b1;
        @(negedge clk); ena_wr = 1'b0;
    endtask

    task automatic wr_fade(input bit en, input int rate);
        fade_en = en; fade_rate = 2'(rate); fade_wr = 1'b1;
        @(negedge clk); fade_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        ms_tick = 1'b1;
        repeat (n) @(negedge clk);
        ms_tick = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", "level", level_o, 0);
        check("R1", "chan", chan_on_o, 0);
        check("R1", "busy", busy_o, 0);
    endtask

    task automatic t_immediate;
        wr_ena(4'b1011);
        wr_bri(20);
        check("R2", "level", level_o, 20);
        check("R2", "busy", busy_o, 0);
        check("R8", "chan lit", chan_on_o, 4'b1011);
        wr_bri(0);
        check("R8", "chan dark", chan_on_o, 0);
        wr_bri(20);
        check("R2", "level again", level_o, 20);
    endtask

    task automatic t_reserved;
        wr_bri(2);
        check("R3", "level after code 2", level_o, 20);
        wr_fade(1'b1, 3);
        check("R3", "target kept", busy_o, 0);
        wr_bri(1);
        ticks(8);
        check("R3", "no fade to code 1", level_o, 20);
    endtask

    task automatic t_fade_up;
        wr_bri(23);
        check("R5", "busy on start", busy_o, 1);
        ticks(7);
        check("R4", "rate 11 before 8th tick", level_o, 20);
        ticks(1);
        check("R4", "rate 11 at 8th tick", level_o, 21);
        ticks(8);
        check("R5", "second step", level_o, 22);
    endtask

    task automatic t_rate;
        wr_fade(1'b1, 2);
        ticks(8);
        check("R6", "no step at old rate", level_o, 22);
        ticks(8);
        check("R6", "step at new rate", level_o, 23);
        check("R5", "busy off at target", busy_o, 0);
        wr_fade(1'b1, 0);
        wr_bri(25);
        ticks(31);
        check("R4", "rate 00 before 32nd", level_o, 23);
        ticks(1);
        check("R4", "rate 00 at 32nd", level_o, 24);
        wr_fade(1'b1, 1);
        ticks(23);
        check("R4", "rate 01 before 24th", level_o, 24);
        ticks(1);
        check("R4", "rate 01 at 24th", level_o, 25);
        check("R5", "busy off", busy_o, 0);
    endtask

    task automatic t_redirect_pause;
        wr_fade(1'b1, 3);
        wr_bri(5);
        ticks(8);
        check("R5", "down step", level_o, 24);
        ticks(5);
        wr_bri(20);
        ticks(7);
        check("R7", "interval restarted", level_o, 24);
        ticks(1);
        check("R7", "continues down", level_o, 23);
        wr_ena(0);
        check("R10", "busy while paused", busy_o, 1);
        check("R8", "mask zero dark", chan_on_o, 0);
        ticks(20);
        check("R10", "held while paused", level_o, 23);
        wr_ena(4'b1111);
        check("R8", "all on", chan_on_o, 4'b1111);
        ticks(8);
        check("R10", "resumed", level_o, 22);
    endtask

    task automatic t_cancel;
        wr_fade(1'b0, 3);
        check("R11", "jump to target", level_o, 20);
        check("R11", "busy off", busy_o, 0);
    endtask

    task automatic t_zero_cross;
        wr_fade(1'b1, 3);
        wr_bri(0);
        ticks(128);
        check("R9", "reached 4", level_o, 4);
        ticks(7);
        check("R9", "still 4", level_o, 4);
        ticks(1);
        check("R9", "4 to 0", level_o, 0);
        check("R8", "dark at 0", chan_on_o, 0);
        check("R5", "idle at 0", busy_o, 0);
        wr_bri(6);
        ticks(8);
        check("R9", "0 to 4", level_o, 4);
        ticks(8);
        check("R9", "4 to 5", level_o, 5);
    endtask

    task automatic t_collision;
        ms_tick = 1'b1;
        repeat (7) @(negedge clk);
        bri_code = 5'd8; bri_wr = 1'b1;
        @(negedge clk);
        bri_wr = 1'b0; ms_tick = 1'b0;
        check("R12", "write beats step", level_o, 5);
        ticks(7);
        check("R12", "full new interval", level_o, 5);
        ticks(1);
        check("R12", "step after interval", level_o, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_immediate;
        t_reserved;
        t_fade_up;
        t_rate;
        t_redirect_pause;
        t_cancel;
        t_zero_cross;
        t_collision;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule